// File: doc/BRIEF.md
# Two-Level Grouped Interrupt Aggregator

This block collects the event lines of a multi-function peripheral chip into one active-low, level-sensitive interrupt line for a host. Every event line owns one bit in one of five 16-bit secondary status words. A rising edge on the line latches that bit. Each status word has its own enable-mask word. Unmasked pending bits are then reduced into a primary summary word, with one bit per functional group, and a top-level mask decides which groups may drive the host line.

The host reaches the block through a synchronous 16-bit register port. Writes are registered. Reads are combinational from the current address. A typical service routine reads the primary word, then reads the status words of the groups it names, and finally writes ones back to acknowledge the sources. A group is not tied to a single status word: the undervoltage group gathers regulator sources from two different status words.

Register addresses: 0 is the primary summary (read-only), 1 is the top-level group mask, 2..6 are status words 0..4, and 7..11 are mask words 0..4. The mask of a status word therefore sits at the status address plus 5. Addresses 12..15 read as zero.

Top module: `irqagg_top`

## Requirements
- R1: After reset every status word is 0x0000, every mask word is 0xFFFF, the top-level mask is 0xFFFF, the primary word is 0 and `irqN` is high.
- R2: A status bit sets in the clock edge at which its event input is first seen high after being low. It then stays set while the input stays high or goes low, and it does not set again without a new rising edge.
- R3: Writing a word to a status address clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: When a rising edge and a write-1 clear of the same status bit land on the same clock edge, the bit ends up set.
- R5: A status read returns the latched bits whatever the masks hold. Positions with no source always read 0 and never set. The unused positions are word 0 bit 15, word 1 bits 10..15, word 2 bits 10..15 and word 3 bits 6..15.
- R6: Primary bit g is 1 exactly when some source of group g is set in its status word and its mask bit is 0 (a mask bit of 1 disables the source). The groups are: word 0 bit 0 -> g0 (thermal), bit 1 -> g1 (button), bits 2..4 -> g2 (power path), bit 5 -> g3 (watchdog), bits 6..7 -> g4 (clock/alarm), bits 8..9 -> g5 (touch), bits 10..14 -> g6 (ADC); word 1 bits 0..7 -> g7 (charger), bits 8..9 -> g8 (current sink); word 3 bits 0..1 -> g9 (high current). Primary bits 12..15 read 0.
- R7: Group g10 (undervoltage) is the OR of the unmasked bits 0..9 of word 2 and bits 2..5 of word 3. It stays set while a source in either word remains pending.
- R8: All sixteen bits of word 4 (general-purpose pins) feed group g11.
- R9: A top-level mask bit of 1 keeps its group from asserting `irqN`. The primary word still reads its unmasked value. Writing 0 to the top mask enables all groups.
- R10: `irqN` is low, starting in the same cycle in which the status bit is set, for as long as any primary bit not masked at the top level is 1. Otherwise it is high.
- R11: Mask words and the top mask read back the value last written. Writes to address 0 are ignored. Addresses 12..15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| evtIn | input | 80 | Event lines; bit 16*w+b feeds status word w bit b |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for reads and writes |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read data for regAddr (combinational) |
| irqN | output | 1 | Host interrupt, active low, level |

## Verification
Two functions can fall on the same edge: the latching of a new event and the host's write-1 acknowledge of that same bit. The bench holds the event low and then, in one cycle, raises it and issues the clearing write, so that both reach the same rising edge. It then reads the status word back and expects the bit to be set. It also repeats the acknowledge alone and expects the bit to clear, which shows that the surviving bit came from the new edge and not from a write that failed.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int REG_COUNT   = 5;
  localparam int WORD_W      = 16;
  localparam int GROUP_COUNT = 12;
  localparam int ADDR_W      = 4;
  localparam int SRC_COUNT   = REG_COUNT * WORD_W;
  localparam int IDX_W       = $clog2(REG_COUNT);
  localparam int PRI_ADDR    = 0;
  localparam int TOP_ADDR    = 1;
  localparam int STAT_BASE   = 2;
  localparam int MASK_OFS    = REG_COUNT;
  localparam int MASK_BASE   = STAT_BASE + MASK_OFS;

  typedef enum logic [2:0] {RD_NONE, RD_PRI, RD_TOP, RD_STAT, RD_MASK} rdKind_e;

  typedef struct packed {
    logic [REG_COUNT-1:0] clrStb;
    logic [REG_COUNT-1:0] maskStb;
    logic                 topStb;
    rdKind_e              rdKind;
    logic [IDX_W-1:0]     rdIdx;
  } ctrl_t;

  // Group owning a status bit, -1 when the position has no source.
  function automatic int srcGroup(int r, int b);
    int g;
    g = -1;
    case (r)
      0: begin
        if (b == 0) g = 0;
        else if (b == 1) g = 1;
        else if (b <= 4) g = 2;
        else if (b == 5) g = 3;
        else if (b <= 7) g = 4;
        else if (b <= 9) g = 5;
        else if (b <= 14) g = 6;
      end
      1: begin
        if (b <= 7) g = 7;
        else if (b <= 9) g = 8;
      end
      2: if (b <= 9) g = 10;
      3: begin
        if (b <= 1) g = 9;
        else if (b <= 5) g = 10;
      end
      4: g = 11;
      default: g = -1;
    endcase
    return g;
  endfunction

  function automatic logic [SRC_COUNT-1:0] groupVec(int g);
    logic [SRC_COUNT-1:0] v;
    for (int i = 0; i < SRC_COUNT; i++)
      v[i] = (srcGroup(i / WORD_W, i % WORD_W) == g);
    return v;
  endfunction

  function automatic logic [SRC_COUNT-1:0] implVec();
    logic [SRC_COUNT-1:0] v;
    for (int i = 0; i < SRC_COUNT; i++)
      v[i] = (srcGroup(i / WORD_W, i % WORD_W) >= 0);
    return v;
  endfunction
endpackage

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
  import irqagg_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrl_t             strobes
);
  always_comb begin
    int a;
    a = int'(regAddr);
    strobes.clrStb  = '0;
    strobes.maskStb = '0;
    strobes.topStb  = 1'b0;
    strobes.rdKind  = RD_NONE;
    strobes.rdIdx   = '0;
    if (a == PRI_ADDR) begin
      strobes.rdKind = RD_PRI;
    end else if (a == TOP_ADDR) begin
      strobes.rdKind = RD_TOP;
      strobes.topStb = wrEn;
    end else if (a >= STAT_BASE && a < STAT_BASE + REG_COUNT) begin
      strobes.rdKind = RD_STAT;
      strobes.rdIdx  = IDX_W'(a - STAT_BASE);
      strobes.clrStb[a - STAT_BASE] = wrEn;
    end else if (a >= MASK_BASE && a < MASK_BASE + REG_COUNT) begin
      strobes.rdKind = RD_MASK;
      strobes.rdIdx  = IDX_W'(a - MASK_BASE);
      strobes.maskStb[a - MASK_BASE] = wrEn;
    end
  end
endmodule

// File: rtl/irqagg_datapath.sv
module irqagg_datapath
  import irqagg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] evtIn,
  input  logic [WORD_W-1:0]    wrData,
  input  ctrl_t                strobes,
  output logic [WORD_W-1:0]    rdData,
  output logic                 irqN,
  output logic [SRC_COUNT-1:0] statusVec,
  output logic [SRC_COUNT-1:0] maskVec,
  output logic [WORD_W-1:0]    topVec
);
  localparam logic [SRC_COUNT-1:0] IMPL = implVec();

  logic [SRC_COUNT-1:0] evtPrev;
  logic [SRC_COUNT-1:0] rise;
  logic [SRC_COUNT-1:0] pending;
  logic [WORD_W-1:0]    statW [REG_COUNT];
  logic [WORD_W-1:0]    maskW [REG_COUNT];
  logic [WORD_W-1:0]    topMask;
  logic [WORD_W-1:0]    primary;

  always_ff @(posedge clk) begin
    if (!rstN) evtPrev <= '0;
    else       evtPrev <= evtIn;
  end

  assign rise = evtIn & ~evtPrev & IMPL;

  for (genvar k = 0; k < REG_COUNT; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        statW[k] <= '0;
        maskW[k] <= '1;
      end else begin
        statW[k] <= (statW[k] & ~(strobes.clrStb[k] ? wrData : '0))
                    | rise[k*WORD_W +: WORD_W];
        if (strobes.maskStb[k]) maskW[k] <= wrData;
      end
    end
    assign statusVec[k*WORD_W +: WORD_W] = statW[k];
    assign maskVec[k*WORD_W +: WORD_W]   = maskW[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN)              topMask <= '1;
    else if (strobes.topStb) topMask <= wrData;
  end
  assign topVec = topMask;

  assign pending = statusVec & ~maskVec;

  for (genvar g = 0; g < WORD_W; g++) begin : g_group
    if (g < GROUP_COUNT) begin : g_live
      localparam logic [SRC_COUNT-1:0] MEMBERS = groupVec(g);
      assign primary[g] = |(pending & MEMBERS);
    end else begin : g_spare
      assign primary[g] = 1'b0;
    end
  end

  assign irqN = ~|(primary & ~topMask);

  always_comb begin
    case (strobes.rdKind)
      RD_PRI:  rdData = primary;
      RD_TOP:  rdData = topMask;
      RD_STAT: rdData = statW[strobes.rdIdx];
      RD_MASK: rdData = maskW[strobes.rdIdx];
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] evtIn,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [WORD_W-1:0]    wrData,
  output logic [WORD_W-1:0]    rdData,
  output logic                 irqN
);
  ctrl_t                strobes;
  logic [SRC_COUNT-1:0] statusVec;
  logic [SRC_COUNT-1:0] maskVec;
  logic [WORD_W-1:0]    topVec;

  irqagg_ctrl u_ctrl (
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  irqagg_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .evtIn     (evtIn),
    .wrData    (wrData),
    .strobes   (strobes),
    .rdData    (rdData),
    .irqN      (irqN),
    .statusVec (statusVec),
    .maskVec   (maskVec),
    .topVec    (topVec)
  );
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
  import irqagg_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [SRC_COUNT-1:0] evtIn,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [WORD_W-1:0]    wrData,
  input logic                 irqN,
  input logic [SRC_COUNT-1:0] statusVec,
  input logic [SRC_COUNT-1:0] maskVec,
  input logic [WORD_W-1:0]    topVec
);
  localparam logic [SRC_COUNT-1:0] IMPL = implVec();

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (irqN && statusVec == '0 && &maskVec && &topVec));

  for (genvar i = 0; i < SRC_COUNT; i++) begin : g_src
    if (IMPL[i]) begin : g_on
      assert_edge_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && evtIn[i] && !$past(evtIn[i])) |=> statusVec[i]);
    end else begin : g_off
      assert_unused_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
        !statusVec[i]);
    end
  end

  assert_clear_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && wrEn && regAddr == ADDR_W'(STAT_BASE) && &wrData &&
     (evtIn[WORD_W-1:0] & ~$past(evtIn[WORD_W-1:0])) == '0)
    |=> statusVec[WORD_W-1:0] == '0);

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && wrEn && regAddr == ADDR_W'(STAT_BASE) && wrData[0] &&
     evtIn[0] && !$past(evtIn[0])) |=> statusVec[0]);

  assert_top_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    &topVec[GROUP_COUNT-1:0] |-> irqN);

  assert_irq_needs_pending_R10: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (statusVec & ~maskVec) != '0);

  assert_irq_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec & ~maskVec) == '0 |-> irqN);
endmodule

bind irqagg_top irqagg_chk u_chk (.*);

// File: tb/sim_irqagg_top.sv
`timescale 1ns/1ps
module sim_irqagg_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [79:0] evtIn = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irqN;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irqagg_top u0 (.clk(clk), .rstN(rstN), .evtIn(evtIn), .wrEn(wrEn),
                 .regAddr(regAddr), .wrData(wrData), .rdData(rdData), .irqN(irqN));

  function automatic int grp(int r, int b);
    if (r == 0) begin
      if (b == 0) return 0;
      if (b == 1) return 1;
      if (b <= 4) return 2;
      if (b == 5) return 3;
      if (b <= 7) return 4;
      if (b <= 9) return 5;
      if (b <= 14) return 6;
      return -1;
    end
    if (r == 1) return (b <= 7) ? 7 : (b <= 9) ? 8 : -1;
    if (r == 2) return (b <= 9) ? 10 : -1;
    if (r == 3) return (b <= 1) ? 9 : (b <= 5) ? 10 : -1;
    return 11;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(int a, output logic [15:0] v);
    regAddr = 4'(a); #1; v = rdData;
  endtask

  task automatic wr(int a, logic [15:0] d);
    regAddr = 4'(a); wrData = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 / R11: reset values and unmapped addresses
    rd(0, v); chk("R1 primary", v, 16'h0);
    rd(1, v); chk("R1 top mask", v, 16'hFFFF);
    for (int r = 0; r < 5; r++) begin
      rd(2 + r, v); chk("R1 status", v, 16'h0);
      rd(7 + r, v); chk("R1 mask", v, 16'hFFFF);
    end
    for (int a = 12; a < 16; a++) begin rd(a, v); chk("R11 unmapped", v, 16'h0); end
    chk("R1 irqN", {15'h0, irqN}, 16'h1);

    // R11: primary is read-only
    wr(0, 16'hFFFF); rd(0, v); chk("R11 primary write ignored", v, 16'h0);

    wr(1, 16'h0000);
    for (int r = 0; r < 5; r++) wr(7 + r, 16'h0000);
    rd(1, v); chk("R11 top readback", v, 16'h0);

    // Sweep every source position: R2 R3 R5 R6 R7 R8 R10
    for (int r = 0; r < 5; r++) begin
      for (int b = 0; b < 16; b++) begin
        int g;
        string tg;
        g = grp(r, b);
        tg = (g == 10) ? "R7 group" : (g == 11) ? "R8 group" : "R6 group";
        evtIn[r*16 + b] = 1'b1;
        tick();
        rd(2 + r, v); chk("R2/R5 latch", v, (g >= 0) ? 16'(1 << b) : 16'h0);
        rd(0, v);     chk(tg, v, (g >= 0) ? 16'(1 << g) : 16'h0);
        chk("R10 irqN", {15'h0, irqN}, (g >= 0) ? 16'h0 : 16'h1);
        evtIn[r*16 + b] = 1'b0;
        tick(); tick();
        rd(2 + r, v); chk("R2 hold", v, (g >= 0) ? 16'(1 << b) : 16'h0);
        wr(2 + r, ~16'(1 << b));
        rd(2 + r, v); chk("R3 zero bits keep", v, (g >= 0) ? 16'(1 << b) : 16'h0);
        wr(2 + r, 16'(1 << b));
        rd(2 + r, v); chk("R3 clear", v, 16'h0);
        chk("R10 release", {15'h0, irqN}, 16'h1);
      end
    end

    // R2: level held high does not re-set after clear
    evtIn[3] = 1'b1; tick();
    wr(2, 16'h0008); tick();
    rd(2, v); chk("R2 no re-set without edge", v, 16'h0);
    evtIn[3] = 1'b0; tick();

    // R5 / R6: masked source latches but stays out of primary
    for (int t = 0; t < 3; t++) begin
      int r, b, g;
      r = (t == 0) ? 0 : (t == 1) ? 2 : 4;
      b = (t == 0) ? 5 : (t == 1) ? 3 : 9;
      g = grp(r, b);
      wr(7 + r, 16'(1 << b));
      rd(7 + r, v); chk("R11 mask readback", v, 16'(1 << b));
      evtIn[r*16 + b] = 1'b1; tick();
      rd(2 + r, v); chk("R5 raw status", v, 16'(1 << b));
      rd(0, v);     chk("R6 masked primary", v, 16'h0);
      chk("R6 masked irqN", {15'h0, irqN}, 16'h1);
      wr(7 + r, 16'h0);
      rd(0, v);     chk("R6 unmasked primary", v, 16'(1 << g));
      chk("R10 unmasked irqN", {15'h0, irqN}, 16'h0);
      evtIn[r*16 + b] = 1'b0;
      wr(2 + r, 16'hFFFF);
    end

    // R4: set and clear on the same edge
    evtIn[16 + 2] = 1'b1;
    wr(3, 16'h0004);
    rd(3, v); chk("R4 set wins", v, 16'h0004);
    evtIn[16 + 2] = 1'b0; tick();
    wr(3, 16'h0004);
    rd(3, v); chk("R4 clear alone", v, 16'h0);

    // R7: undervoltage spans two words
    evtIn[32 + 0] = 1'b1; evtIn[48 + 3] = 1'b1; tick();
    evtIn[32 + 0] = 1'b0; evtIn[48 + 3] = 1'b0;
    wr(4, 16'hFFFF);
    rd(0, v); chk("R7 other word keeps group", v, 16'h0400);
    wr(5, 16'h0008);
    rd(0, v); chk("R7 both cleared", v, 16'h0);

    // R9 / R10: top mask gating and level hold
    evtIn[64] = 1'b1; tick(); evtIn[64] = 1'b0;
    wr(1, 16'h0800);
    chk("R9 gated irqN", {15'h0, irqN}, 16'h1);
    rd(0, v); chk("R9 primary unaffected", v, 16'h0800);
    wr(1, 16'h0000);
    repeat (5) tick();
    chk("R10 level held", {15'h0, irqN}, 16'h0);
    wr(6, 16'h0001);
    chk("R10 released", {15'h0, irqN}, 16'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule